// File: doc/BRIEF.md
# Event Timer with Compare, Capture and Pulse Output

This block is a general-purpose timer for a register-programmed subsystem. A counter of parameterised width (32 bits by default) counts up on each prescaled tick. On wrap it either restarts from zero or loads a reload value. A compare register raises a match event. An external event pin, after synchronisation, can snapshot the counter into a capture register. One output pin can either pulse or toggle on overflow, on match, or on both.

The three event sources (overflow, match, capture) each latch a status bit. The status bits are cleared by writing 1. Enables are changed through separate set and clear words, so one source can be changed without a read-modify-write. A single interrupt line is high while any enabled status bit is set. Software may read and overwrite the counter while it runs.

The register port is a single-cycle valid/write bus. Read data is combinational from the current register state.

Top module: `gp_event_timer`

## Requirements
- R1: Register map (word address on `bus_addr`): 0 control, 1 counter, 2 reload, 3 compare, 4 capture (read-only, writes ignored), 5 status (write 1 to clear), 6 enable-set, 7 enable-clear. Addresses 6 and 7 both read back the enable mask. Control bits:
  - bit 0: run
  - bit 1: reload on wrap
  - bit 2: prescaler enable
  - bits 6:3: prescaler exponent
  - bit 7: compare enable
  - bits 9:8: capture edge, where 00 = off, 01 = rising, 10 = falling, 11 = both
  - bits 11:10: output trigger, where bit 10 = overflow and bit 11 = match
  - bit 12: output mode, where 0 = pulse and 1 = toggle
  - Higher control bits read as zero.
- R2: After reset, every register reads zero, `irq` and `tmr_out` are low, and the counter is stopped with compare and capture disabled.
- R3: With run set and the prescaler off, the counter advances by one on every clock. With run clear, it holds its value.
- R4: With the prescaler enabled and exponent n, the counter advances once every 2^n clocks while running. An exponent above 8 acts as 8. The divider restarts whenever run is clear.
- R5: A tick taken at the all-ones value sets status bit 0 and loads the reload value if reload-on-wrap is set, else zero.
- R6: When compare is enabled and a tick brings the counter to the compare value, status bit 1 is set. When compare is disabled, no match is flagged.
- R7: The capture pin passes a two-flop synchroniser. A selected edge copies the counter into the capture register and sets status bit 2. An unselected edge does neither.
- R8: In pulse mode the output is high for exactly one prescaled tick after a selected event. In toggle mode it inverts on each selected event.
- R9: A counter write takes effect on its clock edge while running. It overrides any tick in that cycle, and counting resumes from the written value.
- R10: `irq` is the OR of status ANDed with enable. Writing 1s to enable-set or enable-clear sets or clears those enable bits. Writing 1 to a status bit clears it, unless the same event fires in that cycle, in which case the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| cap_in | input | 1 | Asynchronous capture event pin |
| tmr_out | output | 1 | Pulse/toggle output |
| irq | output | 1 | Merged interrupt |

## Verification
An overflow tick can land on the same clock edge as a software write-1-to-clear of the overflow status bit. The bench provokes this by loading the counter two below wrap and starting it. It then places the clear write exactly two edges later, on the edge where the wrap occurs. The status read afterwards must still show the overflow bit, because a fresh event must win over a clear. A second collision, a counter write on a running tick edge, is judged by the counter value after one further tick.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses, control-word layout and event indices
// for the event timer. Assumes a word-addressed bus of at least 3 address bits.
package tmr_pkg;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_COUNT  = 1;
    localparam int ADDR_RELOAD = 2;
    localparam int ADDR_CMP    = 3;
    localparam int ADDR_CAP    = 4;
    localparam int ADDR_STAT   = 5;
    localparam int ADDR_ENSET  = 6;
    localparam int ADDR_ENCLR  = 7;

    localparam int NUM_EVT = 3;
    localparam int EV_OVF  = 0;
    localparam int EV_MAT  = 1;
    localparam int EV_CAP  = 2;

    // Control word, bit 0 at the bottom (run).
    typedef struct packed {
        logic       out_toggle;
        logic [1:0] out_trig;
        logic [1:0] cap_edge;
        logic       cmp_en;
        logic [3:0] presc_exp;
        logic       presc_en;
        logic       reload_en;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tick generator. Emits a one-clock tick every 2^n clocks while run is
// high (every clock when bypassed). Exponents above MAX_EXP clamp to MAX_EXP.
// Assumes the divider may restart from zero whenever run drops.
module tmr_prescaler #(
    parameter int MAX_EXP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       en_i,
    input  logic [3:0] exp_i,
    output logic       tick_o
);
    localparam int DIV_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic [3:0]       eff_exp;

    // Clamp the exponent and derive the terminal divider value.
    always_comb begin
        eff_exp = (exp_i > 4'(MAX_EXP)) ? 4'(MAX_EXP) : exp_i;
        limit   = ~({DIV_W{1'b1}} << eff_exp);
        tick_o  = run_i && (!en_i || (div_q >= limit));
    end

    // Divider counter: restarts on each tick or while stopped/bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n)                       div_q <= '0;
        else if (!run_i || !en_i || tick_o) div_q <= '0;
        else                              div_q <= div_q + 1'b1;
    end

    // R4: with a divide ratio above 1, two ticks are never adjacent.
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && en_i && exp_i != 4'd0) |=> (!tick_o || !en_i || exp_i == 4'd0));
    // R3: no tick while stopped.
    p_no_tick_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);
endmodule

// File: rtl/tmr_edge_detect.sv
// Module: synchronises the asynchronous capture pin through SYNC_STAGES flops
// and flags the selected edge (sel: 00 off, 01 rise, 10 fall, 11 both).
// Assumes the pin is held for at least two clocks between transitions.
module tmr_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] sel_i,
    output logic       evt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise, fall;

    // Synchroniser chain and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge qualification against the programmed selection.
    always_comb begin
        rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall  = ~sync_q[SYNC_STAGES-1] & prev_q;
        evt_o = (sel_i[0] & rise) | (sel_i[1] & fall);
    end

    // R7: capture disabled means no event.
    p_cap_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'b00) |-> !evt_o);
    // R7: an event always coincides with a change of the synchronised level.
    p_cap_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Module: per-source status latches (write-1-to-clear, set wins), enable mask
// with separate set/clear strobes, and the merged interrupt line.
module tmr_irq_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we,
    input  logic         set_en_we,
    input  logic         clr_en_we,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q, en_q;

    // Status latches: clear by write-1, new events override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~(clr_we ? wdata_i : '0)) | evt_i;
    end

    // Enable mask: set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | (set_en_we ? wdata_i : '0)) & ~(clr_en_we ? wdata_i : '0);
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = |(stat_q & en_q);

    // R10: every event is visible in status on the next cycle.
    p_evt_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
    // R10: a status bit only rises because of an event.
    p_stat_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));
endmodule

// File: rtl/gp_event_timer.sv
// Module: top of the event timer. Holds the register file, the up counter
// with wrap/reload, compare and capture logic and the output stage.
// Assumes CNT_W <= DATA_W and ADDR_W >= 3; reads are combinational.
module gp_event_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 3,
    parameter int PRESC_MAX   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              irq
);
    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt_q, reload_q, cmp_q, cap_q, cnt_tick;
    logic               out_q;
    logic               wr, wr_ctrl, wr_cnt, wr_rel, wr_cmp, wr_stat, wr_set, wr_clr;
    logic               tick, wrap, ovf_evt, mat_evt, cap_evt, fire;
    logic [NUM_EVT-1:0] evts, stat, en;

    // Write decode.
    always_comb begin
        wr      = bus_valid && bus_write;
        wr_ctrl = wr && (bus_addr == ADDR_W'(ADDR_CTRL));
        wr_cnt  = wr && (bus_addr == ADDR_W'(ADDR_COUNT));
        wr_rel  = wr && (bus_addr == ADDR_W'(ADDR_RELOAD));
        wr_cmp  = wr && (bus_addr == ADDR_W'(ADDR_CMP));
        wr_stat = wr && (bus_addr == ADDR_W'(ADDR_STAT));
        wr_set  = wr && (bus_addr == ADDR_W'(ADDR_ENSET));
        wr_clr  = wr && (bus_addr == ADDR_W'(ADDR_ENCLR));
    end

    tmr_prescaler #(.MAX_EXP(PRESC_MAX)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .en_i(ctrl_q.presc_en),
        .exp_i(ctrl_q.presc_exp), .tick_o(tick)
    );

    tmr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_in), .sel_i(ctrl_q.cap_edge), .evt_o(cap_evt)
    );

    // Next counter value on a tick, and the events it raises.
    always_comb begin
        wrap     = &cnt_q;
        cnt_tick = wrap ? (ctrl_q.reload_en ? reload_q : '0) : cnt_q + 1'b1;
        ovf_evt  = tick && !wr_cnt && wrap;
        mat_evt  = tick && !wr_cnt && ctrl_q.cmp_en && (cnt_tick == cmp_q);
        fire     = (ctrl_q.out_trig[0] && ovf_evt) || (ctrl_q.out_trig[1] && mat_evt);
        evts                 = '0;
        evts[EV_OVF]         = ovf_evt;
        evts[EV_MAT]         = mat_evt;
        evts[EV_CAP]         = cap_evt;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else begin
            if (wr_ctrl) ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_rel)  reload_q <= bus_wdata[CNT_W-1:0];
            if (wr_cmp)  cmp_q    <= bus_wdata[CNT_W-1:0];
        end
    end

    // Counter: software write wins over a tick in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
        else if (tick)   cnt_q <= cnt_tick;
    end

    // Capture register snapshot on a qualified pin edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt_q;
    end

    // Output stage: pulse holds for one tick, toggle flips per event.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= 1'b0;
        else if (tick) out_q <= ctrl_q.out_toggle ? (out_q ^ fire) : fire;
    end

    tmr_irq_ctrl #(.N(NUM_EVT)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt_i(evts), .clr_we(wr_stat), .set_en_we(wr_set),
        .clr_en_we(wr_clr), .wdata_i(bus_wdata[NUM_EVT-1:0]), .stat_o(stat), .en_o(en),
        .irq_o(irq)
    );

    // Read multiplexer.
    always_comb begin
        case (int'(bus_addr))
            ADDR_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            ADDR_COUNT:  bus_rdata = DATA_W'(cnt_q);
            ADDR_RELOAD: bus_rdata = DATA_W'(reload_q);
            ADDR_CMP:    bus_rdata = DATA_W'(cmp_q);
            ADDR_CAP:    bus_rdata = DATA_W'(cap_q);
            ADDR_STAT:   bus_rdata = DATA_W'(stat);
            ADDR_ENSET,
            ADDR_ENCLR:  bus_rdata = DATA_W'(en);
            default:     bus_rdata = '0;
        endcase
    end

    assign tmr_out = out_q;

    // R5: wrap loads reload or zero.
    p_wrap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap && !wr_cnt) |=>
        (cnt_q == ($past(ctrl_q.reload_en) ? $past(reload_q) : '0)));
    // R3: a stopped counter without a software write holds.
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q));
    // R9: software write always lands.
    p_sw_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));
    // R7: capture register holds the counter value at the event.
    p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(cnt_q)));
    // R8: in pulse mode the output drops on a tick without an event.
    p_pulse_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl_q.out_toggle && !fire) |=> !tmr_out);
endmodule

// File: tb/sim_gp_event_timer.sv
module sim_gp_event_timer;
    localparam int A_CTRL = 0, A_CNT = 1, A_REL = 2, A_CMP = 3, A_CAP = 4,
                   A_STAT = 5, A_ENS = 6, A_ENC = 7;
    localparam logic [31:0] C_RUN = 32'h1, C_RLD = 32'h2, C_PEN = 32'h4,
                            C_CMP = 32'h80, C_TGL = 32'h1000;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{3'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{3'd3, 32'h0000_ABCD, 32'h0000_ABCD},
        '{3'd0, 32'hFFFF_FFFE, 32'h0000_1FFE},
        '{3'd0, 32'h0000_0000, 32'h0000_0000},
        '{3'd6, 32'h0000_00FF, 32'h0000_0007},
        '{3'd7, 32'h0000_0005, 32'h0000_0002},
        '{3'd7, 32'h0000_0007, 32'h0000_0000},
        '{3'd4, 32'h0000_1234, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, cap_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rv;
    logic        tmr_out, irq;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gp_event_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'(a);
        #1; d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Run with ctrl for idle+1 clock edges, then stop.
    task automatic run_for(input logic [31:0] c, input int idle);
        wr(A_CTRL, c);
        repeat (idle) @(posedge clk);
        wr(A_CTRL, c & ~C_RUN);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, rv);
            chk("R2 reset reg", rv, 32'h0);
        end
        chk("R2 reset irq", {31'd0, irq}, 32'd0);
        chk("R2 reset out", {31'd0, tmr_out}, 32'd0);

        // R1/R10: register map vectors
        for (int i = 0; i < 8; i++) begin
            wr(int'(VEC[i].addr), VEC[i].wd);
            rd(int'(VEC[i].addr), rv);
            chk("R1 map vector", rv, VEC[i].exp);
        end

        // R3: plain counting and hold
        wr(A_CNT, 0);
        run_for(C_RUN, 9);
        rd(A_CNT, rv); chk("R3 count 10", rv, 32'd10);
        repeat (5) @(posedge clk);
        rd(A_CNT, rv); chk("R3 hold stopped", rv, 32'd10);

        // R4: prescaler 2^2 over 12 edges, and clamped exponent 15 -> 256
        wr(A_CNT, 0);
        run_for(C_RUN | C_PEN | (32'd2 << 3), 11);
        rd(A_CNT, rv); chk("R4 div4", rv, 32'd3);
        wr(A_CNT, 0);
        run_for(C_RUN | C_PEN | (32'd15 << 3), 511);
        rd(A_CNT, rv); chk("R4 clamp div256", rv, 32'd2);

        // R5: wrap with reload, then without
        wr(A_STAT, 7);
        wr(A_REL, 32'h10);
        wr(A_CNT, 32'hFFFF_FFFE);
        run_for(C_RUN | C_RLD, 2);
        rd(A_CNT, rv);  chk("R5 reload", rv, 32'h11);
        rd(A_STAT, rv); chk("R5 ovf status", rv, 32'h1);
        wr(A_STAT, 7);
        wr(A_CNT, 32'hFFFF_FFFE);
        run_for(C_RUN, 2);
        rd(A_CNT, rv);  chk("R5 wrap to zero", rv, 32'h1);

        // R6: match enabled and disabled
        wr(A_STAT, 7);
        wr(A_CMP, 5);
        wr(A_CNT, 0);
        run_for(C_RUN, 7);
        rd(A_STAT, rv); chk("R6 no match when disabled", rv, 32'h0);
        wr(A_CNT, 0);
        run_for(C_RUN | C_CMP, 7);
        rd(A_STAT, rv); chk("R6 match status", rv, 32'h2);

        // R10: merged interrupt via enable set/clear and w1c
        wr(A_ENS, 32'h2);
        chk("R10 irq on", {31'd0, irq}, 32'd1);
        wr(A_ENC, 32'h2);
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        wr(A_ENS, 32'h2);
        wr(A_STAT, 32'h2);
        chk("R10 irq after clear", {31'd0, irq}, 32'd0);
        wr(A_ENC, 32'h7);

        // R8: pulse on match, bypassed prescaler: high one clock
        wr(A_CMP, 3);
        wr(A_CNT, 0);
        wr(A_CTRL, C_RUN | C_CMP | (32'd2 << 10));
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R8 pulse high", {31'd0, tmr_out}, 32'd1);
        @(negedge clk); chk("R8 pulse low", {31'd0, tmr_out}, 32'd0);
        wr(A_CTRL, 0);

        // R8: pulse with prescaler 2^1 lasts two clocks
        wr(A_CMP, 2);
        wr(A_CNT, 0);
        wr(A_CTRL, C_RUN | C_CMP | C_PEN | (32'd1 << 3) | (32'd2 << 10));
        repeat (5) @(posedge clk);
        @(negedge clk); chk("R8 prescaled pulse 2nd clock", {31'd0, tmr_out}, 32'd1);
        @(negedge clk); chk("R8 prescaled pulse end", {31'd0, tmr_out}, 32'd0);
        wr(A_CTRL, 0);

        // R8: toggle mode stays high after one match
        wr(A_CMP, 3);
        wr(A_CNT, 0);
        wr(A_CTRL, C_RUN | C_CMP | C_TGL | (32'd2 << 10));
        repeat (6) @(posedge clk);
        @(negedge clk); chk("R8 toggle held", {31'd0, tmr_out}, 32'd1);
        wr(A_CTRL, 0);

        // R7: capture on rising only, then both edges, then off
        wr(A_STAT, 7);
        wr(A_CNT, 32'h77);
        wr(A_CTRL, 32'h1 << 8);
        @(negedge clk); cap_in = 1'b1;
        repeat (5) @(posedge clk);
        rd(A_CAP, rv);  chk("R7 rise capture", rv, 32'h77);
        rd(A_STAT, rv); chk("R7 capture status", rv, 32'h4);
        wr(A_STAT, 7);
        wr(A_CNT, 32'h88);
        @(negedge clk); cap_in = 1'b0;
        repeat (5) @(posedge clk);
        rd(A_CAP, rv);  chk("R7 falling ignored", rv, 32'h77);
        rd(A_STAT, rv); chk("R7 no status on fall", rv, 32'h0);
        wr(A_CTRL, 32'h3 << 8);
        @(negedge clk); cap_in = 1'b1;
        repeat (5) @(posedge clk);
        rd(A_CAP, rv);  chk("R7 both edges", rv, 32'h88);
        wr(A_CTRL, 0);
        wr(A_CNT, 32'h99);
        @(negedge clk); cap_in = 1'b0;
        repeat (5) @(posedge clk);
        rd(A_CAP, rv);  chk("R7 capture off", rv, 32'h88);

        // R9: write while running overrides the tick
        wr(A_CNT, 0);
        wr(A_CTRL, C_RUN);
        repeat (3) @(posedge clk);
        wr(A_CNT, 32'h100);
        wr(A_CTRL, 0);
        rd(A_CNT, rv); chk("R9 on-the-fly write", rv, 32'h101);

        // R10: overflow on the same edge as its w1c clear -> bit stays
        wr(A_STAT, 7);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, C_RUN);
        @(posedge clk);
        wr(A_STAT, 32'h1);
        wr(A_CTRL, 0);
        rd(A_STAT, rv); chk("R10 set wins over clear", rv, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule